// File: doc/BRIEF.md
# Bulk-In Readiness Controller

This block decides how to answer each host request for a bulk-in packet. It looks at how many bytes wait in the receive FIFO, how long the serial receiver has been idle, and whether the low-latency bit is set. From these it returns either an acknowledge with a packet length, or a refusal (NAK). Full packets of the maximum size always go out. A shorter packet goes out only in two cases: the line has been quiet for longer than a set number of character times, or low latency is enabled.

The receive-idle window is measured in bit-time ticks, so it follows the configured character framing. A character time is one start bit, plus the data bits, plus an optional parity bit, plus one or two stop bits. Every received character restarts the idle count. The caller gives a one-cycle request strobe and reads the decision one clock later. The FIFO itself, the packet signalling and the CRC are outside this block.

Top module: `bulkin_ready_ctl`

## Requirements
- R1: While reset is asserted and just after it, `rsp_valid`, `rsp_ack` and `rsp_len` are 0, and the idle count starts from zero.
- R2: A request on `req_strobe` gives exactly one cycle of `rsp_valid` on the next clock. `rsp_ack` and `rsp_len` are 0 whenever `rsp_valid` is low.
- R3: A FIFO count of 0 always gives NAK with length 0, whatever the idle or low-latency state.
- R4: A FIFO count of 64 or more gives ACK with length 64.
- R5: A count from 1 to 63 gives NAK with length 0 when low latency is off and the idle window has not expired.
- R6: The idle window has expired once more than 3 character times of ticks have passed since the last character. A count from 1 to 63 then gives ACK, with length equal to the count.
- R7: With `low_lat_en`=1, a count from 1 to 63 gives ACK with length equal to the count, whatever the idle state.
- R8: The character length in ticks is 1 + D + P + S. D is `data_bits` clamped to the range 5..9. P is `parity_en`. S is 2 when `two_stop`=1 and 1 otherwise.
- R9: With 9 data bits, the parity bit is not counted in the character length.
- R10: `char_done` clears the idle count. A `bit_tick` in the same cycle as `char_done` is not counted.
- R11: The idle count saturates, so the window stays expired however long the line is quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_count | input | CNT_W | Bytes held in the receive FIFO |
| char_done | input | 1 | One-cycle pulse per received character |
| bit_tick | input | 1 | One pulse per serial bit time |
| data_bits | input | 4 | Configured data bits per character |
| parity_en | input | 1 | Parity bit present in the frame |
| two_stop | input | 1 | Two stop bits when 1 |
| low_lat_en | input | 1 | Send any non-empty contents at once |
| req_strobe | input | 1 | One-cycle host bulk-in request |
| rsp_valid | output | 1 | Decision valid this cycle |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = NAK |
| rsp_len | output | LEN_W | Bytes to send with the acknowledge |

## Verification
The bench sweeps every data-bit setting, including values outside the 5..9 range, together with parity and stop choices. For each setting it places the idle tick count exactly at, just below and just above three character times. A design that gets the boundary off by one, or that mis-sizes the character (for example by counting parity in 9-bit mode, or by skipping the clamp), would release short packets one tick early or late. The bench also tries FIFO counts of 0, 63, 64 and above 64, to catch a design that acknowledges an empty FIFO or reports a length above 64. It also checks a character that lands in the same cycle as a tick, and a very long quiet period, to catch a design that counts that tick or whose counter wraps back to "not expired".

// File: rtl/bulkin_pkg.sv
package bulkin_pkg;
   // Framing settings gathered from the port pins
   typedef struct packed {
      logic [3:0] data_bits;
      logic       parity_en;
      logic       two_stop;
   } frame_cfg_t;

   // Decision presented to the host side
   typedef struct packed {
      logic valid;
      logic ack;
   } rsp_flags_t;

   localparam int unsigned START_BITS = 1;
endpackage

// File: rtl/bulkin_char_len.sv
module bulkin_char_len
   import bulkin_pkg::*;
#(
   parameter int unsigned MIN_DATA         = 5,
   parameter int unsigned MAX_DATA         = 9,
   parameter bit          PARITY_ON_WIDEST = 1'b0,
   parameter int unsigned CL_W             = 4
) (
   input  frame_cfg_t       cfg,
   output logic [CL_W-1:0]  char_len
);
   logic [3:0] data_eff;
   logic       par_bit;

   always_comb begin
      if (cfg.data_bits < 4'(MIN_DATA))
         data_eff = 4'(MIN_DATA);
      else if (cfg.data_bits > 4'(MAX_DATA))
         data_eff = 4'(MAX_DATA);
      else
         data_eff = cfg.data_bits;
   end

   generate
      if (PARITY_ON_WIDEST) begin : g_par_always
         assign par_bit = cfg.parity_en;
      end else begin : g_par_drop_widest
         assign par_bit = cfg.parity_en && (data_eff != 4'(MAX_DATA));
      end
   endgenerate

   always_comb begin
      char_len = CL_W'(START_BITS) + CL_W'(data_eff) + CL_W'(par_bit)
               + (cfg.two_stop ? CL_W'(2) : CL_W'(1));
   end
endmodule

// File: rtl/bulkin_idle_timer.sv
module bulkin_idle_timer #(
   parameter int unsigned IDLE_CHARS = 3,
   parameter int unsigned CL_W       = 4,
   parameter int unsigned TMR_W      = 6,
   parameter int unsigned SAT_VAL    = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             char_done,
   input  logic             bit_tick,
   input  logic [CL_W-1:0]  char_len,
   output logic             expired
);
   logic [TMR_W-1:0] tick_cnt;
   logic [TMR_W-1:0] window;
   logic             at_sat;

   assign at_sat = (tick_cnt == TMR_W'(SAT_VAL));
   assign window = TMR_W'(IDLE_CHARS) * TMR_W'(char_len);

   always_ff @(posedge clk) begin
      if (!rst_n)
         tick_cnt <= '0;
      else if (char_done)
         tick_cnt <= '0;
      else if (bit_tick && !at_sat)
         tick_cnt <= tick_cnt + TMR_W'(1);
   end

   assign expired = (tick_cnt > window);
endmodule

// File: rtl/bulkin_rsp_sel.sv
module bulkin_rsp_sel
   import bulkin_pkg::*;
#(
   parameter int unsigned CNT_W    = 9,
   parameter int unsigned MAX_PKT  = 64,
   parameter int unsigned LEN_W    = 7,
   parameter bit          REG_RESP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_strobe,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic             low_lat_en,
   input  logic             expired,
   output logic             rsp_valid,
   output logic             rsp_ack,
   output logic [LEN_W-1:0] rsp_len
);
   logic             is_empty;
   logic             is_full;
   logic             short_ok;
   rsp_flags_t       nxt_flags;
   logic [LEN_W-1:0] nxt_len;

   assign is_empty = (fifo_count == '0);
   assign is_full  = (fifo_count >= CNT_W'(MAX_PKT));
   assign short_ok = low_lat_en || expired;

   always_comb begin
      nxt_flags = '0;
      nxt_len   = '0;
      if (req_strobe) begin
         nxt_flags.valid = 1'b1;
         if (!is_empty) begin
            if (is_full) begin
               nxt_flags.ack = 1'b1;
               nxt_len       = LEN_W'(MAX_PKT);
            end else if (short_ok) begin
               nxt_flags.ack = 1'b1;
               nxt_len       = LEN_W'(fifo_count);
            end
         end
      end
   end

   generate
      if (REG_RESP) begin : g_registered
         rsp_flags_t       flags_q;
         logic [LEN_W-1:0] len_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags_q <= '0;
               len_q   <= '0;
            end else begin
               flags_q <= nxt_flags;
               len_q   <= nxt_len;
            end
         end
         assign rsp_valid = flags_q.valid;
         assign rsp_ack   = flags_q.ack;
         assign rsp_len   = len_q;
      end else begin : g_direct
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rsp_valid  = nxt_flags.valid;
         assign rsp_ack    = nxt_flags.ack;
         assign rsp_len    = nxt_len;
      end
   endgenerate
endmodule

// File: rtl/bulkin_ready_ctl.sv
module bulkin_ready_ctl
   import bulkin_pkg::*;
#(
   parameter int unsigned CNT_W            = 9,
   parameter int unsigned MAX_PKT          = 64,
   parameter int unsigned IDLE_CHARS       = 3,
   parameter int unsigned MIN_DATA         = 5,
   parameter int unsigned MAX_DATA         = 9,
   parameter bit          PARITY_ON_WIDEST = 1'b0,
   parameter bit          REG_RESP         = 1'b1,
   parameter int unsigned LEN_W            = $clog2(MAX_PKT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic             char_done,
   input  logic             bit_tick,
   input  logic [3:0]       data_bits,
   input  logic             parity_en,
   input  logic             two_stop,
   input  logic             low_lat_en,
   input  logic             req_strobe,
   output logic             rsp_valid,
   output logic             rsp_ack,
   output logic [LEN_W-1:0] rsp_len
);
   localparam int unsigned MAX_CHAR = START_BITS + MAX_DATA + 1 + 2;
   localparam int unsigned CL_W     = $clog2(MAX_CHAR + 1);
   localparam int unsigned SAT_VAL  = IDLE_CHARS * MAX_CHAR + 1;
   localparam int unsigned TMR_W    = $clog2(SAT_VAL + 1);

   // Elaboration-time parameter checks
   if (MAX_PKT < 1) begin : g_bad_pkt
      $error("MAX_PKT must be at least 1");
   end
   if ((1 << CNT_W) <= MAX_PKT) begin : g_bad_cnt
      $error("CNT_W too narrow to hold MAX_PKT");
   end
   if (MIN_DATA > MAX_DATA || MAX_DATA > 15) begin : g_bad_data
      $error("data bit range invalid");
   end
   if (IDLE_CHARS < 1) begin : g_bad_idle
      $error("IDLE_CHARS must be at least 1");
   end
   if ((1 << LEN_W) <= MAX_PKT) begin : g_bad_len
      $error("LEN_W too narrow for MAX_PKT");
   end

   frame_cfg_t       cfg;
   logic [CL_W-1:0]  char_len;
   logic             expired;

   assign cfg = '{data_bits: data_bits, parity_en: parity_en, two_stop: two_stop};

   bulkin_char_len #(
      .MIN_DATA         (MIN_DATA),
      .MAX_DATA         (MAX_DATA),
      .PARITY_ON_WIDEST (PARITY_ON_WIDEST),
      .CL_W             (CL_W)
   ) u_len (
      .cfg      (cfg),
      .char_len (char_len)
   );

   bulkin_idle_timer #(
      .IDLE_CHARS (IDLE_CHARS),
      .CL_W       (CL_W),
      .TMR_W      (TMR_W),
      .SAT_VAL    (SAT_VAL)
   ) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .char_done (char_done),
      .bit_tick  (bit_tick),
      .char_len  (char_len),
      .expired   (expired)
   );

   bulkin_rsp_sel #(
      .CNT_W    (CNT_W),
      .MAX_PKT  (MAX_PKT),
      .LEN_W    (LEN_W),
      .REG_RESP (REG_RESP)
   ) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_strobe (req_strobe),
      .fifo_count (fifo_count),
      .low_lat_en (low_lat_en),
      .expired    (expired),
      .rsp_valid  (rsp_valid),
      .rsp_ack    (rsp_ack),
      .rsp_len    (rsp_len)
   );
endmodule

// File: rtl/bulkin_ready_chk.sv
module bulkin_ready_chk #(
   parameter int unsigned CNT_W    = 9,
   parameter int unsigned MAX_PKT  = 64,
   parameter int unsigned LEN_W    = 7,
   parameter bit          REG_RESP = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] fifo_count,
   input logic             low_lat_en,
   input logic             req_strobe,
   input logic             rsp_valid,
   input logic             rsp_ack,
   input logic [LEN_W-1:0] rsp_len
);
   generate
      if (REG_RESP) begin : g_chk
         // R2
         rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid |-> $past(req_strobe));
         // R2
         quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rsp_valid |-> (!rsp_ack && rsp_len == '0));
         // R3
         empty_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && $past(fifo_count) == '0) |-> !rsp_ack);
         // R4
         full_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && $past(fifo_count) >= CNT_W'(MAX_PKT))
               |-> (rsp_ack && rsp_len == LEN_W'(MAX_PKT)));
         // R7
         low_lat_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && $past(low_lat_en) && $past(fifo_count) != '0
               && $past(fifo_count) < CNT_W'(MAX_PKT))
               |-> (rsp_ack && rsp_len == LEN_W'($past(fifo_count))));
         // R5
         nak_len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && !rsp_ack) |-> rsp_len == '0);
      end
   endgenerate
endmodule

bind bulkin_ready_ctl bulkin_ready_chk #(
   .CNT_W    (CNT_W),
   .MAX_PKT  (MAX_PKT),
   .LEN_W    (LEN_W),
   .REG_RESP (REG_RESP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_count (fifo_count),
   .low_lat_en (low_lat_en),
   .req_strobe (req_strobe),
   .rsp_valid  (rsp_valid),
   .rsp_ack    (rsp_ack),
   .rsp_len    (rsp_len)
);

// File: tb/sim_bulkin_ready_ctl.sv
`timescale 1ns/1ps
module sim_bulkin_ready_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] fifo_count = '0;
   logic       char_done = 1'b0;
   logic       bit_tick = 1'b0;
   logic [3:0] data_bits = 4'd8;
   logic       parity_en = 1'b0;
   logic       two_stop = 1'b0;
   logic       low_lat_en = 1'b0;
   logic       req_strobe = 1'b0;
   logic       rsp_valid;
   logic       rsp_ack;
   logic [6:0] rsp_len;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bulkin_ready_ctl u0 (
      .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .char_done(char_done),
      .bit_tick(bit_tick), .data_bits(data_bits), .parity_en(parity_en),
      .two_stop(two_stop), .low_lat_en(low_lat_en), .req_strobe(req_strobe),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_len(rsp_len)
   );

   // R8 / R9: expected character length from the requirements
   function automatic int char_ticks(int d, bit p, bit s);
      int dd;
      dd = (d < 5) ? 5 : ((d > 9) ? 9 : d);
      return 1 + dd + ((p && dd != 9) ? 1 : 0) + (s ? 2 : 1);
   endfunction

   task automatic do_ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) bit_tick = 1'b1;
         @(negedge clk) bit_tick = 1'b0;
      end
   endtask

   task automatic pulse_char();
      @(negedge clk) char_done = 1'b1;
      @(negedge clk) char_done = 1'b0;
   endtask

   task automatic probe(int cnt, bit ll, bit expd, string tag);
      bit eack;
      int elen;
      eack = (cnt != 0) && (cnt >= 64 || ll || expd);
      elen = eack ? ((cnt >= 64) ? 64 : cnt) : 0;
      @(negedge clk);
      fifo_count = 9'(cnt);
      low_lat_en = ll;
      req_strobe = 1'b1;
      @(negedge clk);
      req_strobe = 1'b0;
      n_vec++;
      if (rsp_valid !== 1'b1 || rsp_ack !== eack || int'(rsp_len) != elen) begin
         n_bad++;
         $display("FAIL %s cnt=%0d ll=%0d: got v=%0b a=%0b len=%0d exp v=1 a=%0b len=%0d",
                  tag, cnt, ll, rsp_valid, rsp_ack, rsp_len, eack, elen);
      end
      @(negedge clk);
      if (rsp_valid !== 1'b0 || rsp_ack !== 1'b0 || rsp_len !== 7'd0) begin
         n_bad++;
         $display("FAIL R2 pulse width: got v=%0b a=%0b len=%0d exp 0 0 0",
                  rsp_valid, rsp_ack, rsp_len);
      end
   endtask

   function automatic string tag_for(int cnt, bit ll, bit expd);
      if (cnt == 0) return "R3";
      if (cnt >= 64) return "R4";
      if (ll) return "R7";
      if (expd) return "R6";
      return "R5";
   endfunction

   initial begin
      int cnts[7] = '{0, 1, 37, 63, 64, 65, 300};
      int L;
      int offs[4];
      repeat (3) @(negedge clk);
      // R1: reset state
      n_vec++;
      if (rsp_valid !== 1'b0 || rsp_ack !== 1'b0 || rsp_len !== 7'd0) begin
         n_bad++;
         $display("FAIL R1 reset outputs: got %0b %0b %0d exp 0 0 0", rsp_valid, rsp_ack, rsp_len);
      end
      @(negedge clk) rst_n = 1'b1;
      // R1: idle count starts at zero, so 3 char times of ticks is not expired
      L = char_ticks(8, 0, 0);
      do_ticks(3 * L);
      probe(10, 0, 0, "R1");
      do_ticks(1);
      probe(10, 0, 1, "R1");

      // R8 R9 sweep over framing and the idle boundary
      for (int d = 3; d <= 10; d++) begin
         for (int p = 0; p <= 1; p++) begin
            for (int s = 0; s <= 1; s++) begin
               @(negedge clk);
               data_bits = 4'(d);
               parity_en = p[0];
               two_stop  = s[0];
               L = char_ticks(d, p[0], s[0]);
               offs = '{0, 3 * L - 1, 3 * L, 3 * L + 1};
               for (int o = 0; o < 4; o++) begin
                  pulse_char();
                  do_ticks(offs[o]);
                  for (int c = 0; c < 7; c++) begin
                     for (int ll = 0; ll <= 1; ll++) begin
                        probe(cnts[c], ll[0], offs[o] > 3 * L,
                              (offs[o] >= 3 * L - 1 && cnts[c] > 0 && cnts[c] < 64 && ll == 0)
                                 ? ((d == 9 || d == 10) && p == 1 ? "R9" : "R8")
                                 : tag_for(cnts[c], ll[0], offs[o] > 3 * L));
                     end
                  end
               end
            end
         end
      end

      // R10: char mid-window restarts count; tick coinciding with char ignored
      @(negedge clk);
      data_bits = 4'd7; parity_en = 1'b1; two_stop = 1'b0;
      L = char_ticks(7, 1, 0);
      pulse_char();
      do_ticks(3 * L);
      @(negedge clk) begin char_done = 1'b1; bit_tick = 1'b1; end
      @(negedge clk) begin char_done = 1'b0; bit_tick = 1'b0; end
      do_ticks(3 * L);
      probe(20, 0, 0, "R10");
      do_ticks(1);
      probe(20, 0, 1, "R10");

      // R11: long quiet period stays expired
      pulse_char();
      do_ticks(300);
      probe(5, 0, 1, "R11");
      do_ticks(50);
      probe(63, 0, 1, "R11");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog: got no completion exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule